// File: doc/BRIEF.md
# Fractional-N Phase Resync Timer

This block runs on the phase-detector clock of a fractional-N synthesizer. It produces a periodic sync tick whose spacing is the product of a programmed clock divider and the fractional modulus. When a new frequency is loaded, it produces a resync trigger. The trigger tells the fractional modulator to reload its phase word, which sets the output phase in steps of 360 degrees divided by the modulus. The tick interval should be programmed no shorter than the worst-case lock time, so that the resync lands after the last cycle slip of the settling transient.

A rising edge on the load strobe marks a new frequency. The next sync tick is skipped, and the tick after that carries the resync trigger. Both outputs are registered single-cycle pulses. With a 40 ns phase-detector period, a modulus of 125 and a divider of 80, the ticks fall every 10,000 cycles, which is 400 us.

Top module: `phase_resync_timer`

## Requirements
- R1: Ticks and resync triggers are produced only while `clk_mode` equals binary 10. Any other mode value keeps both outputs low and holds the interval count at zero. Both outputs are low in reset.
- R2: A divider value of 0, or a modulus of 0, is illegal. The block then stays idle and produces no tick and no resync.
- R3: While enabled with constant settings, `sync_tick` is high for one cycle every `clk_div` × `modulus` cycles. The first tick comes that many cycles after the enable is first sampled.
- R4: Each tick is exactly one cycle wide when the interval is 2 or more. With an interval of 1, `sync_tick` is high on every cycle.
- R5: After a rising edge of `load_en` is sampled while the block is enabled, the first following tick produces no resync. The second tick produces `resync_pulse` for one cycle, in the same cycle as that tick.
- R6: A new rising edge of `load_en` before the resync has fired restarts the two-tick count. A tick that is produced in the same cycle as the edge is sampled counts as earlier than the edge.
- R7: The interval count is `DIV_W`+`MOD_W` bits wide. It never passes the interval, including at the largest product of both fields.
- R8: If the settings shrink the interval below the count already reached, the tick fires on the next edge and the count restarts from zero.
- R9: A `load_en` edge seen while the block is disabled is ignored. Leaving the enabled state drops any pending resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Sync clock divider, legal 1 to 2^DIV_W-1 |
| modulus | input | MOD_W | Fractional modulus |
| clk_mode | input | 2 | Clock mode field, binary 10 selects resync |
| load_en | input | 1 | Load strobe, rising edge marks a new frequency |
| sync_tick | output | 1 | Periodic one-cycle sync tick |
| resync_pulse | output | 1 | One-cycle phase-word reload trigger |

## Verification
The bench builds the timer with `DIV_W` = 4 and `MOD_W` = 4, so every interval lies between 1 and 225 cycles. This brings the largest product of the two fields, the one-cycle interval and every divider/modulus pairing within a short run. Random settings and randomly timed load strobes then reach many phase relations between the load edge and the tick counter. These include edges that coincide with a tick and edges that repeat before a resync has fired.

// File: rtl/phase_resync_pkg.sv
package phase_resync_pkg;
  localparam logic [1:0] MODE_RESYNC = 2'b10;

  typedef enum logic [1:0] {
    ARM_IDLE   = 2'd0,
    ARM_FIRST  = 2'd1,
    ARM_SECOND = 2'd2
  } arm_state_t;
endpackage

// File: rtl/sync_interval_counter.sv
module sync_interval_counter #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [MOD_W-1:0] modulus,
  output logic             tick_now,
  output logic             sync_tick
);
  localparam int CNT_W = DIV_W + MOD_W;

  function automatic logic [CNT_W-1:0] interval_len(input logic [DIV_W-1:0] d,
                                                     input logic [MOD_W-1:0] m);
    logic [CNT_W-1:0] dw;
    logic [CNT_W-1:0] mw;
    dw = CNT_W'(d);
    mw = CNT_W'(m);
    return dw * mw;
  endfunction

  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = interval_len(clk_div, modulus) - CNT_W'(1);
  assign tick_now = en && (elapsed_q >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      sync_tick <= 1'b0;
    end else if (!en) begin
      elapsed_q <= '0;
      sync_tick <= 1'b0;
    end else begin
      elapsed_q <= tick_now ? '0 : elapsed_q + CNT_W'(1);
      sync_tick <= tick_now;
    end
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sync_tick && elapsed_q == '0)); // R1
  AST_ZERO_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div == '0) |=> !sync_tick); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(clk_div) && $stable(modulus)) |-> (elapsed_q <= last_idx)); // R7
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick_now |=> (elapsed_q == '0 && sync_tick)); // R8
endmodule

// File: rtl/resync_arm.sv
module resync_arm
  import phase_resync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load_en,
  input  logic tick_now,
  output logic load_rise,
  output logic resync_pulse
);
  logic       load_q;
  arm_state_t arm_q;
  logic       fire_now;

  assign load_rise = load_en && !load_q;
  assign fire_now  = en && tick_now && (arm_q == ARM_SECOND) && !load_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q       <= 1'b0;
      arm_q        <= ARM_IDLE;
      resync_pulse <= 1'b0;
    end else begin
      load_q       <= load_en;
      resync_pulse <= fire_now;
      if (!en) begin
        arm_q <= ARM_IDLE;
      end else if (load_rise) begin
        arm_q <= ARM_FIRST;
      end else if (tick_now) begin
        case (arm_q)
          ARM_FIRST:  arm_q <= ARM_SECOND;
          ARM_SECOND: arm_q <= ARM_IDLE;
          default:    arm_q <= ARM_IDLE;
        endcase
      end
    end
  end

  AST_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_rise) |=> (arm_q == ARM_FIRST && !resync_pulse)); // R6
  AST_FIRST_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == ARM_FIRST && tick_now && !load_rise) |=> !resync_pulse); // R5
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (arm_q == ARM_IDLE && !resync_pulse)); // R9
  AST_SINGLE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse); // R5
endmodule

// File: rtl/phase_resync_timer.sv
module phase_resync_timer
  import phase_resync_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [MOD_W-1:0] modulus,
  input  logic [1:0]       clk_mode,
  input  logic             load_en,
  output logic             sync_tick,
  output logic             resync_pulse
);
  logic cfg_legal;
  logic timer_en;
  logic tick_now;
  logic load_rise;

  assign cfg_legal = (clk_div != '0) && (modulus != '0);
  assign timer_en  = (clk_mode == MODE_RESYNC) && cfg_legal;

  sync_interval_counter #(
    .DIV_W(DIV_W),
    .MOD_W(MOD_W)
  ) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (timer_en),
    .clk_div  (clk_div),
    .modulus  (modulus),
    .tick_now (tick_now),
    .sync_tick(sync_tick)
  );

  resync_arm u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (timer_en),
    .load_en     (load_en),
    .tick_now    (tick_now),
    .load_rise   (load_rise),
    .resync_pulse(resync_pulse)
  );

  AST_RESYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> sync_tick); // R5
  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode != MODE_RESYNC) |=> (!sync_tick && !resync_pulse)); // R1
  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_tick |-> $past(timer_en)); // R3
endmodule

// File: tb/sim_phase_resync_timer.sv
module sim_phase_resync_timer;
  localparam int DW = 4;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] div_i = '0;
  logic [MW-1:0] mod_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic          le_i = 1'b0;
  logic          tick_o;
  logic          rs_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int m_elapsed = 0;
  int m_wait = 0;
  bit m_le_prev = 0;
  bit e_tick = 0;
  bit e_rs = 0;

  always #10 clk = ~clk;

  phase_resync_timer #(.DIV_W(DW), .MOD_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(div_i), .modulus(mod_i),
    .clk_mode(mode_i), .load_en(le_i), .sync_tick(tick_o), .resync_pulse(rs_o)
  );

  function automatic int period_of(int d, int m);
    return d * m;
  endfunction

  function automatic bit active_cfg(logic [1:0] md, int d, int m);
    return (md == 2'b10) && (d != 0) && (m != 0);
  endfunction

  task automatic check_bit(string t, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rise;
    bit fire;
    int per;
    rise = le_i && !m_le_prev;
    m_le_prev = le_i;
    if (!rst_n) begin
      m_le_prev = 0; m_elapsed = 0; m_wait = 0; e_tick = 0; e_rs = 0;
    end else if (!active_cfg(mode_i, div_i, mod_i)) begin
      m_elapsed = 0; m_wait = 0; e_tick = 0; e_rs = 0;
    end else begin
      per  = period_of(div_i, mod_i);
      fire = (m_elapsed + 1 >= per);
      e_tick = fire;
      e_rs = fire && (m_wait == 2) && !rise;
      if (rise) m_wait = 1;
      else if (fire) m_wait = (m_wait == 1) ? 2 : 0;
      m_elapsed = fire ? 0 : m_elapsed + 1;
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      check_bit(tag, "sync_tick", tick_o, e_tick);
      check_bit(tag, "resync_pulse", rs_o, e_rs);
      le_i = 1'b0;
    end
  endtask

  task automatic setup(logic [1:0] md, int d, int m);
    mode_i = md; div_i = DW'(d); mod_i = MW'(m);
  endtask

  task automatic load_pulse();
    le_i = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rs_seen;
    void'($urandom(32'd20240611));
    @(negedge clk);
    tag = "R1"; cyc(3);
    rst_n = 1'b1;
    // R1: non-resync modes stay silent even with load strobes
    foreach (tag[i]) ;
    tag = "R1"; setup(2'b01, 3, 2); cyc(10); load_pulse(); cyc(20);
    setup(2'b11, 3, 2); cyc(20); setup(2'b00, 1, 1); cyc(10);
    // R2: zero divider or zero modulus is idle
    tag = "R2"; setup(2'b10, 0, 5); cyc(20); load_pulse(); cyc(20);
    setup(2'b10, 5, 0); cyc(20);
    // R3: period 12, then resync timing R5
    setup(2'b00, 3, 4); cyc(2);
    tag = "R3"; setup(2'b10, 3, 4); cyc(50);
    tag = "R5"; rs_seen = 0;
    load_pulse();
    for (int i = 0; i < 40; i++) begin cyc(1); if (rs_o) rs_seen++; end
    checks++;
    if (rs_seen != 1) begin errors++; $display("FAIL R5 resync count actual=%0d expected=1", rs_seen); end
    // R4: interval of one
    tag = "R4"; setup(2'b10, 1, 1); cyc(8); load_pulse(); cyc(6);
    tag = "R4"; setup(2'b10, 1, 2); cyc(10);
    // R7: largest product
    setup(2'b00, 15, 15); cyc(2);
    tag = "R7"; setup(2'b10, 15, 15); cyc(470); load_pulse(); cyc(460);
    // R6: repeated load before resync
    setup(2'b00, 3, 4); cyc(2);
    tag = "R6"; setup(2'b10, 3, 4); cyc(5); load_pulse(); cyc(15); load_pulse(); cyc(20);
    load_pulse(); cyc(30);
    // R6: load edge in the cycle of a tick (tick at count 11 of 12)
    setup(2'b00, 3, 4); cyc(2); setup(2'b10, 3, 4); cyc(11); load_pulse(); cyc(40);
    // R8: shrink interval mid-count
    setup(2'b00, 15, 4); cyc(2);
    tag = "R8"; setup(2'b10, 15, 4); cyc(40); setup(2'b10, 2, 4); cyc(30);
    // R9: load while disabled, and disable while armed
    tag = "R9"; setup(2'b00, 2, 3); cyc(2); load_pulse(); cyc(2);
    setup(2'b10, 2, 3); cyc(30);
    load_pulse(); cyc(7); setup(2'b01, 2, 3); cyc(3); setup(2'b10, 2, 3); cyc(30);
    // random episodes
    tag = "R5";
    for (int ep = 0; ep < 60; ep++) begin
      int len;
      setup(2'b00, 1, 1); cyc(2);
      setup(($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'b10,
            $urandom_range(1, 15), $urandom_range(1, 15));
      len = $urandom_range(100, 400);
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(0, 40) == 0) le_i = 1'b1;
        cyc(1);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule